// File: doc/BRIEF.md
# Interleaved Thread Issue Front End with Flow-ID Pool

This block sits at the front of a fine-grained multithreaded core. Eight hardware threads each keep their own program counter. Every cycle the block issues one instruction slot, and it takes the threads in a fixed rotation. A thread gets its next slot only after all the other threads have had theirs. The core pipeline is shorter than the rotation, so an instruction has always resolved before the next one from the same thread arrives. No hazard, stall or thread-switch logic is needed. Each thread advances at one-eighth of the clock rate, and its timing is fully deterministic.

A thread whose run enable is low keeps its slot, but that slot carries a bubble. The rotation never shortens.

Next to the issue logic sits a pool of flow IDs. Its size is set at synthesis. When a new data block enters the system, it requests an ID through the alloc handshake. When the block leaves, the ID comes back through the free port. The pool always offers its lowest free ID. When every ID is taken it drops ready and refuses requests. A free of an ID that is not held raises an error pulse and leaves the pool as it was.

Top module: `mt_issue_front`

## Requirements
- R1: `issue_tid` takes the values 0,1,...,NTHR-1,0,... on successive cycles, one per cycle, starting at 0 on the first clock edge after reset is released.
- R2: A slot whose thread has `run_en` low has `issue_valid` = 0, and that thread's PC is left unchanged. The slot is still consumed.
- R3: After reset, thread t's PC equals t*PC_STRIDE. Each valid issue presents the thread's current PC on `issue_pc`, and the next issue of that thread presents it plus one.
- R4: `alloc_ready` is 1 exactly when at least one ID is free. `alloc_id` is then the lowest-numbered free ID.
- R5: An ID is granted when `alloc_req` is high at a clock edge while `alloc_ready` is high. An `alloc_req` while `alloc_ready` is low changes nothing.
- R6: A `free_req` naming a held ID returns that ID to the pool one edge later, where it is again eligible as the lowest free ID.
- R7: A `free_req` naming an ID that is not held, or an ID of NID or more, sets `free_err` high for exactly the one cycle after that edge and leaves the pool unchanged.
- R8: While reset is high, `issue_valid` = 0, `issue_tid` = 0, `alloc_ready` = 1, `alloc_id` = 0, `free_err` = 0, and every ID is free.
- R9: An alloc and a valid free in the same cycle both take effect. The grant uses the ID offered before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | NTHR | Per-thread run enable |
| issue_valid | output | 1 | Current slot carries an instruction |
| issue_tid | output | $clog2(NTHR) | Thread owning the current slot |
| issue_pc | output | PCW | PC issued in the current slot |
| alloc_req | input | 1 | Request a flow ID |
| alloc_ready | output | 1 | A flow ID is available |
| alloc_id | output | $clog2(NID) | Lowest free flow ID |
| free_req | input | 1 | Return a flow ID |
| free_id | input | $clog2(NID) | Flow ID being returned |
| free_err | output | 1 | Previous free named an ID not held |

## Verification
The bench changes the run-enable pattern in the middle of a rotation. A design that skipped disabled threads would then shorten the rotation, and one that advanced a disabled PC would show a jump on its next valid issue. The pool is driven through a double free, a free of an ID that was never granted, an alloc and free in the same cycle, and a full pool that keeps being asked for an ID. A wrong design would, in turn, corrupt the bitmap, grant a duplicate or non-lowest ID, or keep ready high with nothing left. The same-cycle case catches a design where the free overrides the grant.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_ALLOC = 2'd1, OP_FREE = 2'd2, OP_BOTH = 2'd3} pool_op_e;

  function automatic int wrap_inc(input int v, input int n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/mt_rr_sched.sv
module mt_rr_sched #(
  parameter int NTHR = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= TW'(mt_pkg::wrap_inc(int'(slot), NTHR));
  end
endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
  parameter int NTHR      = 8,
  parameter int PCW       = 16,
  parameter int PC_STRIDE = 256,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   slot,
  input  logic [NTHR-1:0] run_en,
  output logic            issue_valid,
  output logic [TW-1:0]   issue_tid,
  output logic [PCW-1:0]  issue_pc
);
  logic [PCW-1:0] pc_mem [NTHR];
  logic           go;

  assign go = run_en[slot];

  for (genvar t = 0; t < NTHR; t++) begin : g_pc
    always_ff @(posedge clk) begin
      if (rst)                          pc_mem[t] <= PCW'(t * PC_STRIDE);
      else if (go && slot == TW'(t))    pc_mem[t] <= pc_mem[t] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= '0;
    end else begin
      issue_valid <= go;
      issue_tid   <= slot;
      issue_pc    <= pc_mem[slot];
    end
  end
endmodule

// File: rtl/mt_id_pool.sv
module mt_id_pool #(
  parameter int NID = 8,
  localparam int IDW = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_req,
  output logic           alloc_ready,
  output logic [IDW-1:0] alloc_id,
  input  logic           free_req,
  input  logic [IDW-1:0] free_id,
  output logic           free_err,
  output logic [NID-1:0] used
);
  logic [NID-1:0] used_n;
  logic           take, free_hit, any_n;
  logic [IDW-1:0] low_n;

  assign take     = alloc_req && alloc_ready;
  assign free_hit = free_req && (int'(free_id) < NID) && used[free_id];

  always_comb begin
    used_n = used;
    if (take)     used_n[alloc_id] = 1'b1;
    if (free_hit) used_n[free_id]  = 1'b0;
  end

  always_comb begin
    any_n = 1'b0;
    low_n = '0;
    for (int i = NID - 1; i >= 0; i--) begin
      if (!used_n[i]) begin
        any_n = 1'b1;
        low_n = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used        <= '0;
      alloc_ready <= 1'b1;
      alloc_id    <= '0;
      free_err    <= 1'b0;
    end else begin
      used        <= used_n;
      alloc_ready <= any_n;
      alloc_id    <= low_n;
      free_err    <= free_req && !free_hit;
    end
  end
endmodule

// File: rtl/mt_issue_front.sv
module mt_issue_front #(
  parameter int NTHR      = 8,
  parameter int PCW       = 16,
  parameter int PC_STRIDE = 256,
  parameter int NID       = 8,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int IDW = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] run_en,
  output logic            issue_valid,
  output logic [TW-1:0]   issue_tid,
  output logic [PCW-1:0]  issue_pc,
  input  logic            alloc_req,
  output logic            alloc_ready,
  output logic [IDW-1:0]  alloc_id,
  input  logic            free_req,
  input  logic [IDW-1:0]  free_id,
  output logic            free_err
);
  logic [TW-1:0]  slot;
  logic [NID-1:0] pool_map;

  mt_rr_sched #(.NTHR(NTHR)) u_sched (.clk(clk), .rst(rst), .slot(slot));

  mt_pc_bank #(.NTHR(NTHR), .PCW(PCW), .PC_STRIDE(PC_STRIDE)) u_pcs (
    .clk(clk), .rst(rst), .slot(slot), .run_en(run_en),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  mt_id_pool #(.NID(NID)) u_pool (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_ready(alloc_ready),
    .alloc_id(alloc_id), .free_req(free_req), .free_id(free_id),
    .free_err(free_err), .used(pool_map)
  );
endmodule

// File: rtl/mt_issue_chk.sv
module mt_issue_chk #(
  parameter int NTHR = 8,
  parameter int NID  = 8,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int IDW = (NID > 1) ? $clog2(NID) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic [TW-1:0]  issue_tid,
  input logic           alloc_req,
  input logic           alloc_ready,
  input logic [IDW-1:0] alloc_id,
  input logic           free_req,
  input logic           free_err,
  input logic [NID-1:0] pool_map
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)         age <= '0;
    else if (!age[1]) age <= age + 1'b1;
  end

  assert_rotate_R1: assert property (@(posedge clk) disable iff (rst)
    age[1] |-> int'(issue_tid) == mt_pkg::wrap_inc(int'($past(issue_tid)), NTHR));

  assert_ready_R4: assert property (@(posedge clk) disable iff (rst)
    alloc_ready == (pool_map != {NID{1'b1}}));

  assert_offer_free_R4: assert property (@(posedge clk) disable iff (rst)
    alloc_ready |-> !pool_map[alloc_id]);

  assert_refuse_R5: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !alloc_ready && !free_req) |=> $stable(pool_map));

  assert_err_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (age[1] && free_err && !$past(alloc_req && alloc_ready)) |-> $stable(pool_map));
endmodule

bind mt_issue_front mt_issue_chk #(.NTHR(NTHR), .NID(NID)) u_chk (
  .clk(clk), .rst(rst), .issue_tid(issue_tid), .alloc_req(alloc_req),
  .alloc_ready(alloc_ready), .alloc_id(alloc_id), .free_req(free_req),
  .free_err(free_err), .pool_map(pool_map)
);

// File: tb/sim_mt_issue_front.sv
module sim_mt_issue_front;
  import mt_pkg::*;
  localparam int NTHR = 8, PCW = 16, STRIDE = 256, NID = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  run_en = 8'hFF;
  logic        issue_valid, alloc_req = 1'b0, alloc_ready, free_req = 1'b0, free_err;
  logic [2:0]  issue_tid, alloc_id, free_id = 3'd0;
  logic [15:0] issue_pc;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mt_issue_front #(.NTHR(NTHR), .PCW(PCW), .PC_STRIDE(STRIDE), .NID(NID)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_pc(issue_pc), .alloc_req(alloc_req),
    .alloc_ready(alloc_ready), .alloc_id(alloc_id), .free_req(free_req),
    .free_id(free_id), .free_err(free_err));

  // entry: [9:8] op, [7:5] free id, [4] ready after, [3:1] id after, [0] err after
  localparam logic [9:0] VEC [0:8] = '{
    {OP_ALLOC, 3'd0, 1'b1, 3'd1, 1'b0},
    {OP_ALLOC, 3'd0, 1'b1, 3'd2, 1'b0},
    {OP_ALLOC, 3'd0, 1'b1, 3'd3, 1'b0},
    {OP_FREE,  3'd1, 1'b1, 3'd1, 1'b0},
    {OP_FREE,  3'd1, 1'b1, 3'd1, 1'b1},
    {OP_ALLOC, 3'd0, 1'b1, 3'd3, 1'b0},
    {OP_FREE,  3'd5, 1'b1, 3'd3, 1'b1},
    {OP_FREE,  3'd0, 1'b1, 3'd0, 1'b0},
    {OP_BOTH,  3'd2, 1'b1, 3'd2, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pool_op(input logic [1:0] op, input logic [2:0] fid);
    @(negedge clk);
    alloc_req = op[0];
    free_req  = op[1];
    free_id   = fid;
    @(negedge clk);
    alloc_req = 1'b0;
    free_req  = 1'b0;
  endtask

  initial begin
    int mpc [8];
    int slot;
    repeat (3) @(negedge clk);
    chk("R8 valid", issue_valid, 0);
    chk("R8 tid", issue_tid, 0);
    chk("R8 ready", alloc_ready, 1);
    chk("R8 id", alloc_id, 0);
    chk("R8 err", free_err, 0);
    rst = 1'b0;
    for (int t = 0; t < 8; t++) mpc[t] = t * STRIDE;
    slot = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      chk("R1 tid", issue_tid, slot);
      chk("R2 valid", issue_valid, run_en[slot]);
      if (run_en[slot]) begin
        chk("R3 pc", issue_pc, mpc[slot]);
        mpc[slot]++;
      end
      slot = (slot + 1) % 8;
      if (k == 15) run_en = 8'hA5;
    end
    // pool vector table: R4 R5 R6 R7 R9
    for (int v = 0; v < 9; v++) begin
      pool_op(VEC[v][9:8], VEC[v][7:5]);
      chk($sformatf("R4/R6 ready v%0d", v), alloc_ready, VEC[v][4]);
      chk($sformatf("R4/R6/R9 id v%0d", v), alloc_id, VEC[v][3:1]);
      chk($sformatf("R7 err v%0d", v), free_err, VEC[v][0]);
    end
    // held {0,1}; fill the rest
    for (int a = 0; a < 6; a++) begin
      chk("R4 offer lowest", alloc_id, a + 2);
      pool_op(OP_ALLOC, 3'd0);
    end
    chk("R4 full ready", alloc_ready, 0);
    pool_op(OP_ALLOC, 3'd0);
    chk("R5 refused ready", alloc_ready, 0);
    chk("R5 refused err", free_err, 0);
    pool_op(OP_FREE, 3'd7);
    chk("R6 freed ready", alloc_ready, 1);
    chk("R6 freed id", alloc_id, 7);
    pool_op(OP_FREE, 3'd3);
    chk("R6 lower id", alloc_id, 3);
    chk("R7 no err", free_err, 0);
    @(negedge clk);
    chk("R7 one cycle", free_err, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule